// File: doc/BRIEF.md
# Two-Button Sequence Combination Lock

This block is a clocked sequence recognizer. It watches two push-button inputs. One button stands for the digit 0 and the other for the digit 1. The block opens, meaning it raises a registered open flag, only after the fixed five-digit code 0,1,0,1,1 has been keyed in order. It tracks partial matches, so a wrong digit does not always throw away the progress made so far. Instead it falls back to the longest tail of the keyed digits that still starts the code.

Internally the machine has six states: idle, plus one state for each matched prefix length from 1 to 5. A key press counts only on a clock edge where exactly one button is high. While the lock is open, the next counted press starts recognition again from scratch. The code and its length are parameters. The defaults give the five-digit code above.

Top module: `combo_lock`

## Requirements
- R1: While rst_n is low at a rising clock edge, the machine returns to idle and lock_open is 0 after that edge.
- R2: A digit is taken only on an edge where exactly one of key0 and key1 is high. On an edge where both are low or both are high, the state is held, and lock_open keeps its value.
- R3: Taking the digits 0,1,0,1,1 in order from idle sets lock_open to 1 after the edge that takes the fifth digit.
- R4: lock_open is 0 whenever the most recent taken digits do not complete the code. In particular it is 0 after four correct digits and after any wrong final digit.
- R5: On a wrong digit, the machine moves to the state for the longest tail of the taken digits that is also a prefix of the code. For example, 0,1,0,1 followed by 0 leaves the machine at the "0,1,0" state, so a further 1,1 opens the lock. Likewise, 0,0 leaves it at the "0" state.
- R6: While lock_open is 1, the next taken digit is matched as if from idle, and lock_open returns to 0 on that edge.
- R7: A reset in the middle of a code discards the partial match, so the full code must be keyed again to open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| key0 | input | 1 | Button for digit 0 |
| key1 | input | 1 | Button for digit 1 |
| lock_open | output | 1 | Registered flag, 1 while the full code is matched |

## Verification
The hardest situation to reach from the ports is a wrong digit that arrives deep in a partial match and must leave the machine at a non-idle fallback state. One example is a 0 arriving after 0,1,0,1. Getting this wrong is invisible until later digits reveal it. The bench therefore drives overlapping streams such as 0,1,0,1,0,1,1 and 0,0,1,0,1,1, and it checks that the lock opens on exactly the edge that a history-of-digits model predicts. Idle and double-press cycles are also interleaved inside codes and while the lock is open, to show that they hold the state.

// File: rtl/combo_lock_pkg.sv
// Package: shared definitions for the combination lock.
// Assumes one fixed code, given most significant digit first.
package combo_lock_pkg;
    localparam int          CODE_LEN_DEF = 5;
    localparam logic [4:0]  CODE_VAL_DEF = 5'b01011;

    typedef enum logic [1:0] {
        KEY_NONE = 2'b00,
        KEY_ZERO = 2'b01,
        KEY_ONE  = 2'b10,
        KEY_BOTH = 2'b11
    } key_e;
endpackage

// File: rtl/combo_key_decode.sv
// Module: turns the two button levels into "digit taken" plus its value.
// Assumes the buttons are already synchronous and clean (no debounce here).
module combo_key_decode
    import combo_lock_pkg::*;
(
    input  logic key0,
    input  logic key1,
    output logic take,
    output logic digit
);
    key_e key_state;

    // Purpose: classify the pair of button levels.
    always_comb begin
        key_state = key_e'({key1, key0});
        take  = (key_state == KEY_ZERO) || (key_state == KEY_ONE);
        digit = (key_state == KEY_ONE);
    end
endmodule

// File: rtl/combo_seq_next.sv
// Module: next-state function of the prefix-matching recognizer.
// State value k means "k leading code digits matched". LEN means open.
// Assumes LEN is small, since the fallback search is unrolled.
module combo_seq_next #(
    parameter int             LEN  = 5,
    parameter logic [LEN-1:0] CODE = 5'b01011,
    localparam int            SW   = $clog2(LEN + 1)
) (
    input  logic [SW-1:0] state,
    input  logic          take,
    input  logic          digit,
    output logic [SW-1:0] state_next
);
    localparam int            IW       = $clog2(LEN + 1);
    localparam logic [LEN:0]  CODE_EXT = {1'b0, CODE};

    // Code digit i in keying order (first keyed digit is i = 0).
    function automatic logic code_at(input int i);
        return CODE_EXT[IW'(LEN - 1 - i)];
    endfunction

    // Longest tail of (matched prefix of length k, then d) that is a code prefix.
    function automatic logic [SW-1:0] advance(input logic [SW-1:0] k, input logic d);
        logic [LEN:0]  seq;
        logic [SW-1:0] best;
        logic          ok;
        seq  = '0;
        best = '0;
        for (int i = 0; i < LEN; i++)
            if (i < int'(k)) seq[IW'(i)] = code_at(i);
        seq[IW'(k)] = d;
        for (int j = 1; j <= LEN; j++) begin
            if (j <= int'(k) + 1) begin
                ok = 1'b1;
                for (int i = 0; i < LEN; i++)
                    if (i < j && seq[IW'(int'(k) + 1 - j + i)] != code_at(i))
                        ok = 1'b0;
                if (ok) best = SW'(j);
            end
        end
        return best;
    endfunction

    logic [SW-1:0] base;

    // Purpose: restart from idle after an open, otherwise extend the match.
    always_comb begin
        base       = (state == SW'(LEN)) ? '0 : state;
        state_next = take ? advance(base, digit) : state;
    end
endmodule

// File: rtl/combo_lock.sv
// Module: top of the two-button combination lock.
// Holds the match-length register and the registered open flag.
// Assumes a synchronous active-low reset held for at least one edge at start.
module combo_lock
    import combo_lock_pkg::*;
#(
    parameter int             LEN  = CODE_LEN_DEF,
    parameter logic [LEN-1:0] CODE = CODE_VAL_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key0,
    input  logic key1,
    output logic lock_open
);
    localparam int SW = $clog2(LEN + 1);

    logic          take;
    logic          digit;
    logic [SW-1:0] state_q;
    logic [SW-1:0] state_d;

    combo_key_decode u_decode (
        .key0  (key0),
        .key1  (key1),
        .take  (take),
        .digit (digit)
    );

    combo_seq_next #(.LEN(LEN), .CODE(CODE)) u_next (
        .state      (state_q),
        .take       (take),
        .digit      (digit),
        .state_next (state_d)
    );

    // Purpose: register match length and open flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= '0;
            lock_open <= 1'b0;
        end else begin
            state_q   <= state_d;
            lock_open <= (state_d == SW'(LEN));
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == '0 && !lock_open));

    // R2
    hold_on_no_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(state_q) && $stable(lock_open));

    // R3
    open_on_last_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && digit == CODE[0] && state_q == SW'(LEN - 1)) |=> lock_open);

    // R6
    open_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_open && take) |=> !lock_open);

    // R5
    state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q <= SW'(LEN));
endmodule

// File: tb/combo_lock_test.sv
`timescale 1ns/1ps
module combo_lock_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key0 = 1'b0;
    logic key1 = 1'b0;
    logic lock_open;

    int n_cmp = 0;
    int n_bad = 0;

    // Model: digits taken since the last restart.
    logic [4:0] hist = '0;
    int         hcnt = 0;
    logic       m_open = 1'b0;

    combo_lock uut (
        .clk(clk), .rst_n(rst_n), .key0(key0), .key1(key1), .lock_open(lock_open)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic exp, input string req);
        n_cmp++;
        if (lock_open !== exp) begin
            n_bad++;
            $display("FAIL %s: lock_open=%b expected=%b at %0t", req, lock_open, exp, $time);
        end
    endtask

    // One clock with the given buttons; the model follows the requirements.
    task automatic step(input logic k0, input logic k1, input string req);
        key0 = k0;
        key1 = k1;
        @(posedge clk);
        if (!rst_n) begin
            hist = '0; hcnt = 0; m_open = 1'b0;
        end else if (k0 ^ k1) begin
            if (m_open) begin hist = '0; hcnt = 0; end
            hist = {hist[3:0], k1};
            if (hcnt < 5) hcnt++;
            m_open = (hcnt == 5) && (hist == 5'b01011);
        end
        @(negedge clk);
        check(m_open, req);
    endtask

    task automatic dig(input logic d, input string req);
        step(!d, d, req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, "R1");
        check(1'b0, "R1");
        rst_n = 1'b1;
    endtask

    task automatic t_correct();
        dig(0, "R4"); dig(1, "R4"); dig(0, "R4"); dig(1, "R4");
        check(1'b0, "R4");
        dig(1, "R3");
        check(1'b1, "R3");
    endtask

    task automatic t_hold_open();
        step(1'b0, 1'b0, "R2");
        step(1'b1, 1'b1, "R2");
        check(1'b1, "R2");
    endtask

    task automatic t_restart();
        dig(0, "R6");
        check(1'b0, "R6");
        dig(1, "R6"); dig(0, "R6"); dig(1, "R6"); dig(1, "R6");
        check(1'b1, "R6");
        dig(1, "R6");
        check(1'b0, "R6");
    endtask

    task automatic t_overlap();
        t_reset();
        dig(0, "R5"); dig(1, "R5"); dig(0, "R5"); dig(1, "R5"); dig(0, "R5");
        check(1'b0, "R5");
        dig(1, "R5"); dig(1, "R5");
        check(1'b1, "R5");
        t_reset();
        dig(0, "R5"); dig(0, "R5"); dig(1, "R5"); dig(0, "R5"); dig(1, "R5"); dig(1, "R5");
        check(1'b1, "R5");
    endtask

    task automatic t_wrong();
        t_reset();
        dig(1, "R4"); dig(1, "R4"); dig(0, "R4"); dig(1, "R4"); dig(0, "R4");
        dig(1, "R4"); dig(0, "R4");
        check(1'b0, "R4");
        dig(1, "R5"); dig(1, "R5");
        check(1'b1, "R5");
    endtask

    task automatic t_stall_inside();
        t_reset();
        dig(0, "R2"); step(1'b1, 1'b1, "R2"); dig(1, "R2");
        step(1'b0, 1'b0, "R2"); dig(0, "R2"); step(1'b1, 1'b1, "R2");
        dig(1, "R2"); step(1'b0, 1'b0, "R2"); dig(1, "R2");
        check(1'b1, "R2");
    endtask

    task automatic t_mid_reset();
        t_reset();
        dig(0, "R7"); dig(1, "R7"); dig(0, "R7");
        rst_n = 1'b0;
        step(1'b0, 1'b0, "R7");
        rst_n = 1'b1;
        dig(1, "R7"); dig(1, "R7");
        check(1'b0, "R7");
        dig(0, "R7"); dig(1, "R7"); dig(0, "R7"); dig(1, "R7"); dig(1, "R7");
        check(1'b1, "R7");
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_correct();
        t_hold_open();
        t_restart();
        t_overlap();
        t_wrong();
        t_stall_inside();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule